// File: doc/BRIEF.md
# Balance-Aware Measurement Loop Sequencer

This block steps an ADC through a fixed measurement loop for a series battery stack. Each loop covers one voltage slot per cell, one stack-voltage slot and a set of temperature slots. It can also append current-only slots. For every slot it selects the measurement and fires a one-cycle start strobe. It then holds the slot until the converter answers with a done pulse.

The block also sits between the passive balancing controller and the bypass switches. The balancing controller may be host software or an autonomous algorithm. The block forwards the requested balance mask but forces off any switch whose bypass current would corrupt the reading in progress. Those are the measured cell and its direct neighbours during a cell slot, and the top cell during the stack slot. This gating is applied again on every loop.

When balancing is active and the slow-loop bit is set, the block pads each loop with current-only slots. This spaces the voltage readings further apart and raises the average bypass current.

Top module: `bal_meas_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `bal_en` to all zeros, selects slot kind 0 with index 0 and holds `adc_start` low. The first slot after release is the cell 1 voltage slot.
- R2: Slot kinds are encoded as 0 = cell voltage, 1 = stack voltage, 2 = temperature and 3 = current-only. Indices are zero-based, so cell 1 is index 0. Each loop visits cells 0..N_CELLS-1, then the stack slot (index 0), then temperatures 0..N_TEMP-1, then any current-only slots, and then starts again at cell 0.
- R3: Every slot spends one cycle loading the mask and one cycle arming, and then `adc_start` is high for exactly one cycle. The slot then holds until `adc_done` is seen high in the strobe cycle or later. An `adc_done` pulse at any other time is ignored.
- R4: While the voltage slot of cell k is strobed, bit k of `bal_en` is 0.
- R5: While the voltage slot of cell k is strobed, bits k-1 and k+1 of `bal_en` are also 0, wherever those cells exist.
- R6: While the stack slot is strobed, bit N_CELLS-1 (the top cell) of `bal_en` is 0.
- R7: Bit i of `bal_en` drives the bypass switch of cell i+1. Each bit equals the latched request bit unless the current slot gates it off. Temperature and current-only slots gate nothing.
- R8: The gating of R4 to R6 is applied again on every loop.
- R9: If the latched slow bit is 1 and the latched request is non-zero, exactly N_PAD current-only slots follow the temperature slots. Otherwise no current-only slots follow.
- R10: `bal_req` and `slow_en` are latched only in the first cycle of the cell 1 slot. Changes at any other time have no effect until the next loop.
- R11: `bal_en` takes its new value one cycle before the slot's `adc_start` and keeps it until that slot's `adc_done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bal_req | input | N_CELLS | Requested balance mask, bit i = cell i+1 |
| slow_en | input | 1 | Enables current-only padding while balancing |
| adc_done | input | 1 | Conversion of the current slot finished |
| slot_kind | output | 2 | Kind of the selected slot (R2 encoding) |
| slot_idx | output | IDXW | Index within the slot kind |
| adc_start | output | 1 | One-cycle conversion start strobe |
| bal_en | output | N_CELLS | Effective bypass switch enables |

## Verification
The bench builds the block with five cells, two temperature slots and two padding slots. With five cells the loop contains the bottom cell, which has no lower neighbour, the top cell, which has no upper neighbour and is also gated by the stack slot, and three interior cells. The loop is also short enough that many loops run in each scenario. Two padding slots show that the padding count is exact and not just present or absent. The converter model varies its response delay from zero to three cycles and sometimes sends a stray done pulse just after a real one, which exercises the handshake's ignore rule.

// File: rtl/bms_seq_pkg.sv
package bms_seq_pkg;

    typedef enum logic [1:0] {
        SK_CELL  = 2'd0,
        SK_STACK = 2'd1,
        SK_TEMP  = 2'd2,
        SK_CURR  = 2'd3
    } slot_kind_e;

    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_ARM   = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

endpackage

// File: rtl/bms_slot_step.sv
module bms_slot_step
    import bms_seq_pkg::*;
#(
    parameter int N_CELLS = 10,
    parameter int N_TEMP  = 3,
    parameter int N_PAD   = 2,
    parameter int IDXW    = 4
) (
    input  slot_kind_e      kind,
    input  logic [IDXW-1:0] idx,
    input  logic            pad_req,
    output slot_kind_e      nkind,
    output logic [IDXW-1:0] nidx
);
    localparam int PAD_LAST = (N_PAD > 0) ? N_PAD - 1 : 0;

    logic pad_on;

    // the padding variant exists only when the parameter asks for it
    if (N_PAD > 0) begin : g_pad
        assign pad_on = pad_req;
    end else begin : g_nopad
        assign pad_on = 1'b0;
    end

    always_comb begin
        nkind = kind;
        nidx  = idx + IDXW'(1);
        case (kind)
            SK_CELL: begin
                if (idx == IDXW'(N_CELLS - 1)) begin
                    nkind = SK_STACK;
                    nidx  = '0;
                end
            end
            SK_STACK: begin
                nkind = SK_TEMP;
                nidx  = '0;
            end
            SK_TEMP: begin
                if (idx == IDXW'(N_TEMP - 1)) begin
                    nkind = pad_on ? SK_CURR : SK_CELL;
                    nidx  = '0;
                end
            end
            default: begin
                if (idx == IDXW'(PAD_LAST)) begin
                    nkind = SK_CELL;
                    nidx  = '0;
                end
            end
        endcase
    end
endmodule

// File: rtl/bms_bal_gate.sv
module bms_bal_gate
    import bms_seq_pkg::*;
#(
    parameter int N_CELLS = 10,
    parameter int IDXW    = 4
) (
    input  slot_kind_e         kind,
    input  logic [IDXW-1:0]    idx,
    input  logic [N_CELLS-1:0] req,
    output logic [N_CELLS-1:0] eff
);
    logic is_cell;
    logic is_stack;

    assign is_cell  = (kind == SK_CELL);
    assign is_stack = (kind == SK_STACK);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        logic hit_own;
        logic hit_up;
        logic hit_dn;
        logic hit_top;

        assign hit_own = is_cell && (idx == IDXW'(i));

        // cell i+1 measured: this cell is its lower neighbour
        if (i < N_CELLS - 1) begin : g_up
            assign hit_up = is_cell && (idx == IDXW'(i + 1));
        end else begin : g_noup
            assign hit_up = 1'b0;
        end

        // cell i-1 measured: this cell is its upper neighbour
        if (i > 0) begin : g_dn
            assign hit_dn = is_cell && (idx == IDXW'(i - 1));
        end else begin : g_nodn
            assign hit_dn = 1'b0;
        end

        if (i == N_CELLS - 1) begin : g_top
            assign hit_top = is_stack;
        end else begin : g_notop
            assign hit_top = 1'b0;
        end

        assign eff[i] = req[i] & ~(hit_own | hit_up | hit_dn | hit_top);
    end
endmodule

// File: rtl/bal_meas_seq.sv
module bal_meas_seq
    import bms_seq_pkg::*;
#(
    parameter int N_CELLS = 10,
    parameter int N_TEMP  = 3,
    parameter int N_PAD   = 2,
    localparam int SPAN_A = (N_CELLS > N_TEMP) ? N_CELLS : N_TEMP,
    localparam int SPAN_B = (SPAN_A > N_PAD) ? SPAN_A : N_PAD,
    localparam int IDXW   = (SPAN_B > 2) ? $clog2(SPAN_B) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CELLS-1:0] bal_req,
    input  logic               slow_en,
    input  logic               adc_done,
    output logic [1:0]         slot_kind,
    output logic [IDXW-1:0]    slot_idx,
    output logic               adc_start,
    output logic [N_CELLS-1:0] bal_en
);
    typedef struct packed {
        slot_kind_e         kind;
        logic [IDXW-1:0]    idx;
        phase_e             ph;
        logic               start;
        logic [N_CELLS-1:0] bal;
        logic [N_CELLS-1:0] req;
        logic               slow;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        kind:  SK_CELL,
        idx:   '0,
        ph:    PH_SETUP,
        start: 1'b0,
        bal:   '0,
        req:   '0,
        slow:  1'b0
    };

    seq_t s_d, s_q;

    logic               pass_head;
    logic [N_CELLS-1:0] req_use;
    logic [N_CELLS-1:0] eff_mask;
    slot_kind_e         step_kind;
    logic [IDXW-1:0]    step_idx;

    // first cycle of the cell 1 slot opens a new loop
    assign pass_head = (s_q.ph == PH_SETUP) && (s_q.kind == SK_CELL) && (s_q.idx == '0);
    assign req_use   = pass_head ? bal_req : s_q.req;

    bms_bal_gate #(
        .N_CELLS (N_CELLS),
        .IDXW    (IDXW)
    ) u_gate (
        .kind (s_q.kind),
        .idx  (s_q.idx),
        .req  (req_use),
        .eff  (eff_mask)
    );

    bms_slot_step #(
        .N_CELLS (N_CELLS),
        .N_TEMP  (N_TEMP),
        .N_PAD   (N_PAD),
        .IDXW    (IDXW)
    ) u_step (
        .kind    (s_q.kind),
        .idx     (s_q.idx),
        .pad_req (s_q.slow && (|s_q.req)),
        .nkind   (step_kind),
        .nidx    (step_idx)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        case (s_q.ph)
            PH_SETUP: begin
                if (pass_head) begin
                    s_d.req  = bal_req;
                    s_d.slow = slow_en;
                end
                s_d.bal = eff_mask;
                s_d.ph  = PH_ARM;
            end
            PH_ARM: begin
                s_d.start = 1'b1;
                s_d.ph    = PH_WAIT;
            end
            PH_WAIT: begin
                if (adc_done) begin
                    s_d.kind = step_kind;
                    s_d.idx  = step_idx;
                    s_d.ph   = PH_SETUP;
                end
            end
            default: s_d.ph = PH_SETUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_kind = s_q.kind;
    assign slot_idx  = s_q.idx;
    assign adc_start = s_q.start;
    assign bal_en    = s_q.bal;
endmodule

// File: rtl/bal_meas_seq_chk.sv
module bal_meas_seq_chk #(
    parameter int N_CELLS = 10,
    parameter int IDXW    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         slot_kind,
    input logic [IDXW-1:0]    slot_idx,
    input logic               adc_start,
    input logic [N_CELLS-1:0] bal_en
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (bal_en == '0 && slot_kind == 2'd0 && slot_idx == '0 && !adc_start));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    // R4
    own_cell_off_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_start && slot_kind == 2'd0) |-> !bal_en[slot_idx]);

    // R5
    low_nbr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_start && slot_kind == 2'd0 && slot_idx != '0) |-> !bal_en[slot_idx - IDXW'(1)]);

    // R5
    high_nbr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_start && slot_kind == 2'd0 && slot_idx < IDXW'(N_CELLS - 1))
            |-> !bal_en[slot_idx + IDXW'(1)]);

    // R6
    top_cell_off_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_start && slot_kind == 2'd1) |-> !bal_en[N_CELLS-1]);

    // R11
    mask_lead_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> $stable(bal_en));
endmodule

bind bal_meas_seq bal_meas_seq_chk #(
    .N_CELLS (N_CELLS),
    .IDXW    (IDXW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_kind (slot_kind),
    .slot_idx  (slot_idx),
    .adc_start (adc_start),
    .bal_en    (bal_en)
);

// File: tb/sim_bal_meas_seq.sv
module sim_bal_meas_seq;
    localparam int NC = 5;
    localparam int NT = 2;
    localparam int NP = 2;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] bal_req = '0;
    logic          slow_en = 1'b0;
    logic          adc_done = 1'b0;
    logic [1:0]    slot_kind;
    logic [IW-1:0] slot_idx;
    logic          adc_start;
    logic [NC-1:0] bal_en;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bal_meas_seq #(.N_CELLS(NC), .N_TEMP(NT), .N_PAD(NP)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bal_req   (bal_req),
        .slow_en   (slow_en),
        .adc_done  (adc_done),
        .slot_kind (slot_kind),
        .slot_idx  (slot_idx),
        .adc_start (adc_start),
        .bal_en    (bal_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int            m_kind = 0;
    int            m_idx = 0;
    int            m_step = 0;   // 0 load mask, 1 arm, 2 strobe/wait
    bit            m_start = 1'b0;
    logic [NC-1:0] m_bal = '0;
    logic [NC-1:0] m_req = '0;
    bit            m_slow = 1'b0;
    int            m_plan[$];
    bit            m_live = 1'b0;

    function automatic logic [NC-1:0] blocked(input int k, input int i);
        logic [NC-1:0] b = '0;
        for (int c = 0; c < NC; c++) begin
            if (k == 0 && (c == i || c == i - 1 || c == i + 1)) b[c] = 1'b1;
            if (k == 1 && c == NC - 1) b[c] = 1'b1;
        end
        return b;
    endfunction

    always @(posedge clk) begin
        m_live = 1'b1;
        if (rst) begin
            m_kind = 0; m_idx = 0; m_step = 0; m_start = 1'b0;
            m_bal = '0; m_req = '0; m_slow = 1'b0;
            m_plan.delete();
        end else begin
            case (m_step)
                0: begin
                    if (m_kind == 0 && m_idx == 0) begin
                        m_req = bal_req;
                        m_slow = slow_en;
                        m_plan.delete();
                        for (int c = 1; c < NC; c++) m_plan.push_back(c);
                        m_plan.push_back(16);
                        for (int t = 0; t < NT; t++) m_plan.push_back(32 + t);
                        if (m_slow && m_req != '0)
                            for (int p = 0; p < NP; p++) m_plan.push_back(48 + p);
                    end
                    m_bal = m_req & ~blocked(m_kind, m_idx);
                    m_start = 1'b0;
                    m_step = 1;
                end
                1: begin
                    m_start = 1'b1;
                    m_step = 2;
                end
                default: begin
                    m_start = 1'b0;
                    if (adc_done) begin
                        if (m_plan.size() == 0) begin
                            m_kind = 0; m_idx = 0;
                        end else begin
                            int e;
                            e = m_plan.pop_front();
                            m_kind = e / 16;
                            m_idx = e % 16;
                        end
                        m_step = 0;
                    end
                end
            endcase
        end
    end

    // ---------------- per-cycle compare and strobe checks ----------------
    logic [NC-1:0] prev_bal = '0;
    int  pad_seen = 0;
    int  pad_want = 0;
    bit  pass_open = 1'b0;
    int  passes = 0;

    always @(negedge clk) begin
        if (m_live) begin
            chk(int'(slot_kind) == m_kind && int'(slot_idx) == m_idx,
                (m_kind == 3 || slot_kind == 2'd3) ? "R9 slot" : "R2 slot",
                {slot_kind, 8'h0, 5'(slot_idx)}, {m_kind[1:0], 8'h0, 5'(m_idx)});
            chk(adc_start === m_start, "R3 adc_start", 32'(adc_start), 32'(m_start));
            chk(bal_en === m_bal, rst ? "R1 bal_en" : "R7 bal_en", 32'(bal_en), 32'(m_bal));
            if (!rst && adc_start) begin
                // R11: mask settled the cycle before the strobe
                chk(bal_en === prev_bal, "R11 lead", 32'(bal_en), 32'(prev_bal));
                if (slot_kind == 2'd0) begin
                    chk(bal_en[slot_idx] == 1'b0, "R4 own cell", 32'(bal_en), 32'(m_req & ~blocked(0, int'(slot_idx))));
                    if (slot_idx > 0)
                        chk(bal_en[slot_idx - 1] == 1'b0, "R5 lower neighbour", 32'(bal_en), 32'(0));
                    if (int'(slot_idx) < NC - 1)
                        chk(bal_en[slot_idx + 1] == 1'b0, "R5 upper neighbour", 32'(bal_en), 32'(0));
                    if (slot_idx == 0) begin
                        if (pass_open) begin
                            passes++;
                            chk(pad_seen == pad_want, "R9 pad count", 32'(pad_seen), 32'(pad_want));
                        end
                        pass_open = 1'b1;
                        pad_seen = 0;
                        pad_want = (m_slow && m_req != '0) ? NP : 0;
                    end
                end else if (slot_kind == 2'd1) begin
                    chk(bal_en[NC-1] == 1'b0, "R6 top cell", 32'(bal_en), 32'(0));
                end else begin
                    if (slot_kind == 2'd3) pad_seen++;
                    chk(bal_en === m_req, "R7 no gating", 32'(bal_en), 32'(m_req));
                end
            end
            if (rst) begin
                pass_open = 1'b0;
            end
        end
        prev_bal = bal_en;
    end

    // ---------------- converter model ----------------
    int wait_left = -1;
    int seq_n = 0;
    bit stray = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            adc_done = 1'b0; wait_left = -1; stray = 1'b0;
        end else begin
            adc_done = 1'b0;
            if (stray) begin
                adc_done = 1'b1;   // lands in the mask-load cycle: must be ignored
                stray = 1'b0;
            end
            if (adc_start) begin
                wait_left = seq_n % 4;
                seq_n++;
            end
            if (wait_left == 0) begin
                adc_done = 1'b1;
                wait_left = -1;
                stray = (seq_n % 3 == 0);
            end else if (wait_left > 0) begin
                wait_left--;
            end
        end
    end

    task automatic wait_strobe(input logic [1:0] k);
        do @(negedge clk); while (!(adc_start && slot_kind == k));
    endtask

    task automatic check_reset_state();
        chk(bal_en == '0, "R1 bal_en after reset", 32'(bal_en), 32'(0));
        chk(slot_kind == 2'd0 && slot_idx == '0, "R1 slot after reset", 32'(slot_idx), 32'(0));
        chk(adc_start == 1'b0, "R1 start after reset", 32'(adc_start), 32'(0));
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        // balancing off: slow bit alone adds no padding (R9)
        bal_req = '0; slow_en = 1'b1;
        repeat (250) @(negedge clk);

        // all cells requested, normal speed (R4, R5, R6, R8)
        bal_req = 5'h1F; slow_en = 1'b0;
        repeat (250) @(negedge clk);

        // alternate cells with padding, then a mid-loop request change (R10)
        bal_req = 5'h15; slow_en = 1'b1;
        wait_strobe(2'd0);
        wait_strobe(2'd2);
        bal_req = 5'h0A; slow_en = 1'b0;
        wait_strobe(2'd2);
        chk(bal_en == 5'h15, "R10 request held in loop", 32'(bal_en), 32'h15);
        wait_strobe(2'd3);
        chk(bal_en == 5'h15, "R10 slow bit held in loop", 32'(bal_en), 32'h15);
        repeat (250) @(negedge clk);

        // only the top cell requested, padded (R6, R9)
        bal_req = 5'h10; slow_en = 1'b1;
        repeat (250) @(negedge clk);

        // reset in the middle of a loop (R1)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        bal_req = 5'h03;
        repeat (200) @(negedge clk);

        // R8: gating was re-applied on many loops
        chk(passes >= 10, "R8 loops observed", 32'(passes), 32'(10));

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule